// File: doc/BRIEF.md
# Programmable Interval Timer Channel

A single 16-bit down-counting timer channel behind a byte-wide register interface. A host writes control bytes to the control port (address 3) and count bytes to the data port (address 0). It reads the count or a status byte back through the data port. Counting advances only in clock cycles where the counting enable `cnt_en` is high. Each enabled cycle is one tick of the timer's input clock.

The channel supports three binary modes. In terminal-count mode, the output rises once when the count expires. In rate-generator mode, the channel reloads and produces one interrupt per period. In software-strobe mode, the channel gives a single one-tick low strobe. The count-latch and read-back commands take a coherent snapshot of the count while counting goes on, and read-back can also capture status. `tmr_out` carries the output level. `irq_o` pulses for one clock at each timer event.

Top module: `pit_channel`

## Requirements
- R1: After reset, `tmr_out`, `irq_o` and `rdata` are 0, the count is 0 and the status byte reads 0x70 (terminal-count mode, null count set).
- R2: A control byte with select bits[7:6]=00 is accepted as a mode write only if access bits[5:4]=11, bit0 (BCD)=0, and mode bits[3:1] are 000, x10 or 100. Any other control byte with select 00 and non-zero access is ignored, and so is one with select 01 or 10. Status, count and `tmr_out` stay unchanged.
- R3: An accepted mode write stops counting at once. It sets `tmr_out` low for mode 000 and high for the other modes. No `irq_o` occurs until a new count has been fully loaded.
- R4: The reload value is written low byte first, then high byte. It enters the counter on the first `cnt_en` cycle after the high byte. The null-count flag (status bit 6) is 1 from a mode or count write until that load.
- R5: In mode 000 with reload N, `tmr_out` rises and `irq_o` pulses once, N+1 clocks after the high-byte write when `cnt_en` is held high. Neither repeats while the counter keeps wrapping.
- R6: In mode x10 with reload N≥2, `irq_o` pulses every N enabled ticks. The first pulse comes N clocks after the high-byte write. `tmr_out` is low for exactly one tick per period. The count stays within 1..N.
- R7: In mode 100 with reload N, a single one-tick low strobe on `tmr_out` occurs N+1 clocks after the high-byte write, with one `irq_o` pulse.
- R8: Control byte 0x00 freezes a count snapshot while counting continues. The next two data reads return its low byte and then its high byte. A latch command while a snapshot is still unread is ignored.
- R9: Read-back byte 11 c s 0 0 0 1 0 latches the count when c=0 and the status when s=0. Status is read first as {out, null, control bits[5:0]}, then the count low byte, then the count high byte.
- R10: With no latch pending, data reads return the live count, low byte and high byte in turn. The count does not change in cycles with `cnt_en` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Register select: 0 data, 3 control |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe, data in `rdata` the next cycle |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Registered read byte |
| cnt_en | input | 1 | Counting-clock enable, one tick per high cycle |
| tmr_out | output | 1 | Timer output level |
| irq_o | output | 1 | One-clock interrupt pulse per timer event |

## Verification
A wrong load pointer or null flag shows as a misplaced status bit 6, or as an event offset by whole periods. Both are visible at the first read-back or the first `irq_o` after a load, within N+2 clocks. A stale or overwritten snapshot returns a count other than the one frozen while `cnt_en` was low, and this appears on the very next pair of data reads. A broken stop or one-shot guard shows as extra `irq_o` pulses within one wrap of the counter, or as a wrong `tmr_out` level in the cycle after a mode write.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = 2 * BYTE_W;
  localparam int unsigned CFG_W  = BYTE_W - 2;

  typedef enum logic [1:0] {MD_TERM, MD_RATE, MD_STROBE, MD_NONE} pit_mode_e;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd3;
  localparam logic [1:0] SEL_CH    = 2'b00;
  localparam logic [1:0] SEL_RB    = 2'b11;
  localparam logic [1:0] ACC_LATCH = 2'b00;
  localparam logic [1:0] ACC_PAIR  = 2'b11;
  localparam logic [CFG_W-1:0] CFG_RESET = 6'b110000;

  function automatic pit_mode_e mode_of(input logic [2:0] m);
    if (m == 3'b000)      return MD_TERM;
    if (m[1:0] == 2'b10)  return MD_RATE;
    if (m == 3'b100)      return MD_STROBE;
    return MD_NONE;
  endfunction
endpackage

// File: rtl/pit_regs.sv
module pit_regs
  import pit_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        addr,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              load_ack,
  output logic [CFG_W-1:0]  cfg,
  output pit_mode_e         mode,
  output pit_mode_e         new_mode,
  output logic [CNT_W-1:0]  reload,
  output logic              load_pend,
  output logic              null_cnt,
  output logic              mode_wr,
  output logic              hi_wr,
  output logic              latch_cmd,
  output logic              rb_cnt,
  output logic              rb_st
);
  logic              ctrl_wr, data_wr, hi_next;
  logic [BYTE_W-1:0] lo_byte;
  logic [1:0]        sel, acc;

  always_comb begin
    ctrl_wr   = wr_en && (addr == ADDR_CTRL);
    data_wr   = wr_en && (addr == ADDR_DATA);
    sel       = wdata[7:6];
    acc       = wdata[5:4];
    new_mode  = mode_of(wdata[3:1]);
    mode      = mode_of(cfg[3:1]);
    mode_wr   = ctrl_wr && (sel == SEL_CH) && (acc == ACC_PAIR) &&
                !wdata[0] && (new_mode != MD_NONE);
    latch_cmd = ctrl_wr && (sel == SEL_CH) && (acc == ACC_LATCH);
    rb_cnt    = ctrl_wr && (sel == SEL_RB) && !wdata[5] && wdata[1];
    rb_st     = ctrl_wr && (sel == SEL_RB) && !wdata[4] && wdata[1];
    hi_wr     = data_wr && hi_next;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg       <= CFG_RESET;
      reload    <= '0;
      lo_byte   <= '0;
      hi_next   <= 1'b0;
      load_pend <= 1'b0;
      null_cnt  <= 1'b1;
    end else begin
      if (load_ack) begin
        load_pend <= 1'b0;
        null_cnt  <= 1'b0;
      end
      if (mode_wr) begin
        cfg       <= wdata[CFG_W-1:0];
        hi_next   <= 1'b0;
        load_pend <= 1'b0;
        null_cnt  <= 1'b1;
      end else if (data_wr) begin
        null_cnt <= 1'b1;
        if (hi_next) begin
          reload    <= {wdata, lo_byte};
          load_pend <= 1'b1;
          hi_next   <= 1'b0;
        end else begin
          lo_byte <= wdata;
          hi_next <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pit_count.sv
module pit_count
  import pit_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  pit_mode_e        mode,
  input  pit_mode_e        new_mode,
  input  logic             mode_wr,
  input  logic             hi_wr,
  input  logic             load_pend,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             run,
  output logic             tmr_out,
  output logic             irq,
  output logic             load_ack
);
  logic done;

  assign load_ack = cnt_en && load_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      run     <= 1'b0;
      done    <= 1'b0;
      tmr_out <= 1'b0;
      irq     <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (mode_wr) begin
        run     <= 1'b0;
        done    <= 1'b0;
        tmr_out <= (new_mode != MD_TERM);
      end else if (load_ack) begin
        count   <= reload;
        run     <= 1'b1;
        done    <= 1'b0;
        tmr_out <= (mode != MD_TERM);
      end else begin
        if (cnt_en && run) begin
          unique case (mode)
            MD_TERM: begin
              count <= count - 1'b1;
              if (count == 1 && !done) begin
                tmr_out <= 1'b1;
                irq     <= 1'b1;
                done    <= 1'b1;
              end
            end
            MD_RATE: begin
              if (count == 1) begin
                count   <= reload;
                tmr_out <= 1'b1;
              end else if (count == 2) begin
                count   <= count - 1'b1;
                tmr_out <= 1'b0;
                irq     <= 1'b1;
              end else begin
                count <= count - 1'b1;
              end
            end
            MD_STROBE: begin
              count <= count - 1'b1;
              if (count == 1 && !done) begin
                tmr_out <= 1'b0;
                irq     <= 1'b1;
                done    <= 1'b1;
              end else begin
                tmr_out <= 1'b1;
              end
            end
            default: ;
          endcase
        end
        if (hi_wr && mode == MD_TERM) tmr_out <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pit_readout.sv
module pit_readout
  import pit_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        addr,
  input  logic              rd_en,
  input  logic              mode_wr,
  input  logic              latch_cmd,
  input  logic              rb_cnt,
  input  logic              rb_st,
  input  logic [CNT_W-1:0]  count,
  input  logic [BYTE_W-1:0] status,
  output logic [BYTE_W-1:0] rdata,
  output logic              cl_active,
  output logic [CNT_W-1:0]  snap
);
  logic              cl_hi, st_active, live_hi, data_rd;
  logic [BYTE_W-1:0] st_byte;

  assign data_rd = rd_en && (addr == ADDR_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata     <= '0;
      cl_active <= 1'b0;
      cl_hi     <= 1'b0;
      snap      <= '0;
      st_active <= 1'b0;
      st_byte   <= '0;
      live_hi   <= 1'b0;
    end else begin
      if (mode_wr) begin
        cl_active <= 1'b0;
        cl_hi     <= 1'b0;
        st_active <= 1'b0;
        live_hi   <= 1'b0;
      end else begin
        if ((latch_cmd || rb_cnt) && !cl_active) begin
          snap      <= count;
          cl_active <= 1'b1;
          cl_hi     <= 1'b0;
        end
        if (rb_st && !st_active) begin
          st_byte   <= status;
          st_active <= 1'b1;
        end
      end
      if (data_rd) begin
        if (st_active) begin
          rdata     <= st_byte;
          st_active <= 1'b0;
        end else if (cl_active) begin
          rdata <= cl_hi ? snap[CNT_W-1:BYTE_W] : snap[BYTE_W-1:0];
          cl_hi <= !cl_hi;
          if (cl_hi) cl_active <= 1'b0;
        end else begin
          rdata   <= live_hi ? count[CNT_W-1:BYTE_W] : count[BYTE_W-1:0];
          live_hi <= !live_hi;
        end
      end else if (rd_en) begin
        rdata <= '0;
      end
    end
  end
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic              cnt_en,
  output logic              tmr_out,
  output logic              irq_o
);
  logic [CFG_W-1:0]  cfg;
  pit_mode_e         mode, new_mode;
  logic [CNT_W-1:0]  reload, count, snap;
  logic              load_pend, null_cnt, mode_wr, hi_wr, latch_cmd;
  logic              rb_cnt, rb_st, load_ack, run, cl_active;
  logic [BYTE_W-1:0] status;

  assign status = {tmr_out, null_cnt, cfg};

  pit_regs u_regs (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .load_ack(load_ack), .cfg(cfg), .mode(mode), .new_mode(new_mode),
    .reload(reload), .load_pend(load_pend), .null_cnt(null_cnt),
    .mode_wr(mode_wr), .hi_wr(hi_wr), .latch_cmd(latch_cmd),
    .rb_cnt(rb_cnt), .rb_st(rb_st)
  );

  pit_count u_count (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .mode(mode), .new_mode(new_mode),
    .mode_wr(mode_wr), .hi_wr(hi_wr), .load_pend(load_pend), .reload(reload),
    .count(count), .run(run), .tmr_out(tmr_out), .irq(irq_o),
    .load_ack(load_ack)
  );

  pit_readout u_read (
    .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .mode_wr(mode_wr),
    .latch_cmd(latch_cmd), .rb_cnt(rb_cnt), .rb_st(rb_st), .count(count),
    .status(status), .rdata(rdata), .cl_active(cl_active), .snap(snap)
  );
endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk
  import pit_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             cnt_en,
  input logic             mode_wr,
  input logic             load_ack,
  input logic             load_pend,
  input logic             irq_o,
  input logic             tmr_out,
  input logic             run,
  input pit_mode_e        mode,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] reload,
  input logic             cl_active,
  input logic [CNT_W-1:0] snap
);
  logic fired;

  always_ff @(posedge clk) begin
    if (rst || mode_wr || load_ack) fired <= 1'b0;
    else if (irq_o && mode == MD_TERM) fired <= 1'b1;
  end

  a_r3_quiet: assert property (@(posedge clk) disable iff (rst)
    mode_wr |=> !irq_o);

  a_r4_load: assert property (@(posedge clk) disable iff (rst)
    load_ack |=> (run && count == $past(reload)));

  a_r5_single: assert property (@(posedge clk) disable iff (rst)
    (fired && mode == MD_TERM) |-> !irq_o);

  a_r6_bound: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_RATE && run && !load_pend && reload > 1) |->
      (count != 0 && count <= reload));

  a_r6_one_low: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_RATE && run && !tmr_out && cnt_en && !mode_wr) |=> tmr_out);

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (cl_active && $past(cl_active)) |-> $stable(snap));
endmodule

bind pit_channel pit_channel_chk u_chk (
  .clk(clk), .rst(rst), .cnt_en(cnt_en), .mode_wr(mode_wr),
  .load_ack(load_ack), .load_pend(load_pend), .irq_o(irq_o),
  .tmr_out(tmr_out), .run(run), .mode(mode), .count(count),
  .reload(reload), .cl_active(cl_active), .snap(snap)
);

// File: tb/pit_channel_bench.sv
module pit_channel_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] addr = 2'd0;
  logic       wr_en = 1'b0, rd_en = 1'b0, cnt_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       tmr_out, irq_o;

  int checks = 0, errors = 0;
  int cyc = 0, irq_n = 0, low_n = 0, c1 = 0;
  int irq_at [8];

  always #10 clk = ~clk;

  pit_channel u_pit_channel (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .cnt_en(cnt_en), .tmr_out(tmr_out),
    .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    if (irq_o) begin
      if (irq_n < 8) irq_at[irq_n] = cyc;
      irq_n++;
    end
    if (!tmr_out) low_n++;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic clr_log();
    irq_n = 0;
    low_n = 0;
    for (int i = 0; i < 8; i++) irq_at[i] = 0;
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    step();
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] v);
    addr = a; rd_en = 1'b1;
    step();
    v = rdata;
    rd_en = 1'b0;
  endtask

  task automatic tick_once();
    cnt_en = 1'b1;
    step();
    cnt_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 tmr_out", {15'd0, tmr_out}, 16'd0);
    chk("R1 irq", {15'd0, irq_o}, 16'd0);
    chk("R1 rdata", {8'd0, rdata}, 16'd0);
    bus_wr(2'd3, 8'hC2);
    bus_rd(2'd0, v); chk("R1 status", {8'd0, v}, 16'h0070);
    bus_rd(2'd0, v); chk("R1 count lo", {8'd0, v}, 16'h0000);
    bus_rd(2'd0, v); chk("R1 count hi", {8'd0, v}, 16'h0000);
  endtask

  task automatic t_mode0();
    cnt_en = 1'b1;
    bus_wr(2'd3, 8'h30);
    bus_wr(2'd0, 8'h05);
    bus_wr(2'd0, 8'h00);
    c1 = cyc; clr_log();
    steps(30);
    chk("R5 irq count", irq_n[15:0], 16'd1);
    chk("R5 irq time", 16'(irq_at[0] - c1), 16'd6);
    chk("R5 out held high", {15'd0, tmr_out}, 16'd1);
    cnt_en = 1'b0;
  endtask

  task automatic t_null();
    logic [7:0] v;
    cnt_en = 1'b0;
    bus_wr(2'd3, 8'h30);
    bus_wr(2'd0, 8'h07);
    cnt_en = 1'b1; steps(3); cnt_en = 1'b0;
    bus_wr(2'd3, 8'hC2);
    bus_rd(2'd0, v); chk("R4 null before high byte", {8'd0, v}, 16'h0070);
    bus_rd(2'd0, v);
    bus_rd(2'd0, v);
    bus_wr(2'd0, 8'h00);
    tick_once();
    bus_wr(2'd3, 8'hC2);
    bus_rd(2'd0, v); chk("R4 null cleared", {8'd0, v}, 16'h0030);
    bus_rd(2'd0, v); chk("R4 loaded lo", {8'd0, v}, 16'h0007);
    bus_rd(2'd0, v); chk("R4 loaded hi", {8'd0, v}, 16'h0000);
  endtask

  task automatic t_latch();
    logic [7:0] v;
    cnt_en = 1'b0;
    bus_wr(2'd3, 8'h30);
    bus_wr(2'd0, 8'h34);
    bus_wr(2'd0, 8'h12);
    tick_once();
    bus_wr(2'd3, 8'h00);
    cnt_en = 1'b1; steps(10); cnt_en = 1'b0;
    bus_wr(2'd3, 8'h00);
    bus_rd(2'd0, v); chk("R8 snapshot lo", {8'd0, v}, 16'h0034);
    bus_rd(2'd0, v); chk("R8 snapshot hi", {8'd0, v}, 16'h0012);
    bus_wr(2'd3, 8'h00);
    bus_rd(2'd0, v); chk("R8 new snapshot lo", {8'd0, v}, 16'h002A);
    bus_rd(2'd0, v); chk("R8 new snapshot hi", {8'd0, v}, 16'h0012);
    bus_rd(2'd0, v); chk("R10 live lo", {8'd0, v}, 16'h002A);
    bus_rd(2'd0, v); chk("R10 live hi", {8'd0, v}, 16'h0012);
  endtask

  task automatic t_rate();
    logic [7:0] lo, hi;
    cnt_en = 1'b1;
    bus_wr(2'd3, 8'h34);
    chk("R3 rate out high", {15'd0, tmr_out}, 16'd1);
    bus_wr(2'd0, 8'h04);
    bus_wr(2'd0, 8'h00);
    c1 = cyc; clr_log();
    steps(18);
    chk("R6 irq count", irq_n[15:0], 16'd4);
    chk("R6 first irq", 16'(irq_at[0] - c1), 16'd4);
    chk("R6 period a", 16'(irq_at[1] - irq_at[0]), 16'd4);
    chk("R6 period b", 16'(irq_at[3] - irq_at[2]), 16'd4);
    chk("R6 low ticks", low_n[15:0], 16'd4);
    bus_wr(2'd3, 8'h00);
    bus_rd(2'd0, lo);
    bus_rd(2'd0, hi);
    chk("R6 latched within 1..N", {15'd0, ({hi, lo} >= 16'd1 && {hi, lo} <= 16'd4)}, 16'd1);
  endtask

  task automatic t_stop();
    logic [7:0] a, b, v;
    bus_wr(2'd3, 8'h30);
    chk("R3 out low after stop", {15'd0, tmr_out}, 16'd0);
    clr_log();
    bus_wr(2'd3, 8'h00);
    bus_rd(2'd0, a); bus_rd(2'd0, v);
    steps(20);
    bus_wr(2'd3, 8'h00);
    bus_rd(2'd0, b); bus_rd(2'd0, v);
    chk("R3 count frozen", {8'd0, b}, {8'd0, a});
    bus_wr(2'd0, 8'h03);
    steps(5);
    chk("R3 no irq while stopped", irq_n[15:0], 16'd0);
    bus_wr(2'd0, 8'h00);
    c1 = cyc; clr_log();
    steps(10);
    chk("R3 resumes after load", irq_n[15:0], 16'd1);
    chk("R3 resume timing", 16'(irq_at[0] - c1), 16'd4);
    cnt_en = 1'b0;
  endtask

  task automatic t_strobe();
    cnt_en = 1'b1;
    bus_wr(2'd3, 8'h38);
    chk("R3 strobe out high", {15'd0, tmr_out}, 16'd1);
    bus_wr(2'd0, 8'h03);
    bus_wr(2'd0, 8'h00);
    c1 = cyc; clr_log();
    steps(40);
    chk("R7 irq count", irq_n[15:0], 16'd1);
    chk("R7 strobe time", 16'(irq_at[0] - c1), 16'd4);
    chk("R7 strobe width", low_n[15:0], 16'd1);
    chk("R7 out back high", {15'd0, tmr_out}, 16'd1);
    cnt_en = 1'b0;
  endtask

  task automatic t_readback();
    logic [7:0] v;
    cnt_en = 1'b0;
    bus_wr(2'd3, 8'h34);
    bus_wr(2'd0, 8'h03);
    bus_wr(2'd0, 8'h02);
    tick_once();
    bus_wr(2'd3, 8'hC2);
    bus_rd(2'd0, v); chk("R9 status", {8'd0, v}, 16'h00B4);
    bus_rd(2'd0, v); chk("R9 count lo", {8'd0, v}, 16'h0003);
    bus_rd(2'd0, v); chk("R9 count hi", {8'd0, v}, 16'h0002);
    bus_wr(2'd3, 8'hD2);
    bus_rd(2'd0, v); chk("R9 count only lo", {8'd0, v}, 16'h0003);
    bus_rd(2'd0, v); chk("R9 count only hi", {8'd0, v}, 16'h0002);
    bus_wr(2'd3, 8'h35);
    bus_wr(2'd3, 8'h14);
    bus_wr(2'd3, 8'h3A);
    bus_wr(2'd3, 8'h74);
    chk("R2 out unchanged", {15'd0, tmr_out}, 16'd1);
    bus_wr(2'd3, 8'hC2);
    bus_rd(2'd0, v); chk("R2 status unchanged", {8'd0, v}, 16'h00B4);
    bus_rd(2'd0, v); chk("R2 count lo unchanged", {8'd0, v}, 16'h0003);
    bus_rd(2'd0, v); chk("R2 count hi unchanged", {8'd0, v}, 16'h0002);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_mode0();
    t_null();
    t_latch();
    t_rate();
    t_stop();
    t_strobe();
    t_readback();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule